// File: doc/BRIEF.md
# Page Write Buffer with Erase/Write Cycle Timer

This block sits behind a serial memory front end and turns one write transaction into a burst of array writes. An address load fixes the page (upper address bits) and the starting byte offset (lower five bits). Each following data strobe deposits one byte into a 32-entry page latch and advances the offset, wrapping inside the page. Every stored byte sets a bit in a valid mask, so only the locations actually received are later written.

When the transaction ends with a STOP strobe, the block scans the latch once, lowest offset first, and drives one array write for each valid location. It then holds a busy flag until a parameterised number of coarse timer ticks (one per millisecond on silicon, a few in simulation) has arrived. While busy, every strobe from the front end is ignored. A write-protect level discards data bytes, and a STOP that arrives with nothing stored, or with protection on, ends the transaction quietly without a busy window.

Top module: `page_write_buffer`

## Requirements
- R1: After reset, `busy` and `mem_we` are low.
- R2: An accepted address load takes `addr_in[10:5]` as the page and `addr_in[4:0]` as the starting offset, and empties the valid mask, discarding any bytes received since the previous load.
- R3: Each accepted data byte is stored at the current offset, and the offset then steps by one modulo 32 (31 goes to 0) while the page stays fixed.
- R4: When more than 32 bytes arrive before STOP, a later byte overwrites the earlier one at the same offset, and only the last value is written to the array.
- R5: After a committing STOP, the array receives exactly one write per received offset, at address `{page, offset}` with the latched data, in strictly ascending offset order within one page; offsets not received are not written.
- R6: `busy` rises in the cycle after a committing STOP is sampled, stays high through the 32-cycle scan (ticks during the scan are not counted), and falls on the clock edge that samples the CYCLE_TICKS-th tick after the scan.
- R7: While `busy` is high, address loads, data strobes and STOP strobes have no effect on the buffer, the offset or the page.
- R8: A data strobe sampled while `wp` is high is discarded and does not advance the offset.
- R9: A STOP with no stored bytes, or sampled while `wp` is high, raises no `busy`, writes nothing, and empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_load | input | 1 | Strobe: take `addr_in` as page and start offset |
| addr_in | input | 11 | Page number (upper 6 bits) and byte offset (lower 5 bits) |
| byte_stb | input | 1 | Strobe: one data byte on `byte_data` |
| byte_data | input | 8 | Data byte |
| stop_stb | input | 1 | Strobe: transaction ended |
| wp | input | 1 | Write-protect level, high blocks writes |
| tick | input | 1 | Coarse timer pulse for the erase/write window |
| busy | output | 1 | Erase/write cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest situation to reach is strobes arriving while the block is busy, since a correct design leaves no trace of them in the array. The stimulus fires a load to a different page, data bytes and a STOP in the middle of the scan, then after `busy` falls sends bytes with no new load and a bare STOP: only if the busy-time strobes were ignored do those bytes land right after the previous transaction's last offset and the bare STOP stay silent. A sweep over every start offset with lengths of 1, 7, 32 and 37 bytes covers page wrap and overwrite, with the expected array built arithmetically.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    // Phase of the commit sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_HOLD = 2'd2
    } pwb_state_e;

endpackage

// File: rtl/pwb_addr_ctr.sv
module pwb_addr_ctr #(
    parameter int PAGE_W = 6,
    parameter int OFFS_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [PAGE_W+OFFS_W-1:0] load_addr,
    input  logic                     step,
    output logic [PAGE_W-1:0]        page,
    output logic [OFFS_W-1:0]        offs
);

    typedef struct packed {
        logic [PAGE_W-1:0] page;
        logic [OFFS_W-1:0] offs;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (load) begin
            ctr_d.page = load_addr[PAGE_W+OFFS_W-1:OFFS_W];
            ctr_d.offs = load_addr[OFFS_W-1:0];
        end else if (step) begin
            // natural wrap of the offset field keeps the page fixed
            ctr_d.offs = ctr_q.offs + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign page = ctr_q.page;
    assign offs = ctr_q.offs;

endmodule

// File: rtl/pwb_page_latch.sv
module pwb_page_latch #(
    parameter int PAGE_BYTES = 32,
    parameter int DATA_W     = 8,
    parameter int OFFS_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFFS_W-1:0] wr_offs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clear,
    input  logic [OFFS_W-1:0] rd_offs,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              any_valid
);

    typedef struct packed {
        logic [PAGE_BYTES-1:0]             vld;
        logic [PAGE_BYTES-1:0][DATA_W-1:0] dat;
    } lat_t;

    lat_t lat_d, lat_q;
    logic [PAGE_BYTES-1:0] hit;

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
        assign hit[g] = wr_en && (wr_offs == OFFS_W'(g));
    end

    always_comb begin
        lat_d = lat_q;
        for (int i = 0; i < PAGE_BYTES; i++) begin
            if (clear) begin
                lat_d.vld[i] = 1'b0;
            end else if (hit[i]) begin
                lat_d.vld[i] = 1'b1;
                lat_d.dat[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    assign rd_data   = lat_q.dat[rd_offs];
    assign rd_valid  = lat_q.vld[rd_offs];
    assign any_valid = |lat_q.vld;

endmodule

// File: rtl/pwb_commit_seq.sv
module pwb_commit_seq
    import pwb_pkg::*;
#(
    parameter int PAGE_BYTES  = 32,
    parameter int OFFS_W      = 5,
    parameter int CYCLE_TICKS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              tick,
    output logic              busy,
    output logic              scan_en,
    output logic [OFFS_W-1:0] scan_idx,
    output logic              scan_last
);

    localparam int TCNT_W = $clog2(CYCLE_TICKS + 1);
    localparam logic [OFFS_W-1:0] LAST_IDX  = OFFS_W'(PAGE_BYTES - 1);
    localparam logic [TCNT_W-1:0] LAST_TICK = TCNT_W'(CYCLE_TICKS - 1);

    typedef struct packed {
        pwb_state_e        st;
        logic [OFFS_W-1:0] idx;
        logic [TCNT_W-1:0] tcnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        case (seq_q.st)
            ST_IDLE: begin
                if (start) begin
                    seq_d.st  = ST_SCAN;
                    seq_d.idx = '0;
                end
            end
            ST_SCAN: begin
                if (seq_q.idx == LAST_IDX) begin
                    seq_d.st   = ST_HOLD;
                    seq_d.tcnt = '0;
                end else begin
                    seq_d.idx = seq_q.idx + 1'b1;
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (seq_q.tcnt == LAST_TICK) seq_d.st = ST_IDLE;
                    else                         seq_d.tcnt = seq_q.tcnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: ST_IDLE, idx: '0, tcnt: '0};
        else        seq_q <= seq_d;
    end

    assign busy      = (seq_q.st != ST_IDLE);
    assign scan_en   = (seq_q.st == ST_SCAN);
    assign scan_idx  = seq_q.idx;
    assign scan_last = scan_en && (seq_q.idx == LAST_IDX);

endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer #(
    parameter int PAGE_BYTES  = 32,
    parameter int PAGES       = 64,
    parameter int DATA_W      = 8,
    parameter int CYCLE_TICKS = 10,
    localparam int OFFS_W     = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = $clog2(PAGES),
    localparam int ADDR_W     = PAGE_W + OFFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              byte_stb,
    input  logic [DATA_W-1:0] byte_data,
    input  logic              stop_stb,
    input  logic              wp,
    input  logic              tick,
    output logic              busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    logic              load_ok, byte_ok, stop_ok, start, clear;
    logic [PAGE_W-1:0] cur_page;
    logic [OFFS_W-1:0] cur_offs;
    logic              scan_en, scan_last;
    logic [OFFS_W-1:0] scan_idx;
    logic [DATA_W-1:0] rd_data;
    logic              rd_valid, any_valid;

    // Front-end acceptance: nothing is taken while busy; load beats byte beats stop
    always_comb begin
        load_ok = addr_load && !busy;
        byte_ok = byte_stb && !busy && !wp && !addr_load;
        stop_ok = stop_stb && !busy && !addr_load && !byte_stb;
        start   = stop_ok && !wp && any_valid;
        clear   = load_ok || (stop_ok && !start) || scan_last;
    end

    pwb_addr_ctr #(
        .PAGE_W (PAGE_W),
        .OFFS_W (OFFS_W)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_ok),
        .load_addr (addr_in),
        .step      (byte_ok),
        .page      (cur_page),
        .offs      (cur_offs)
    );

    pwb_page_latch #(
        .PAGE_BYTES (PAGE_BYTES),
        .DATA_W     (DATA_W),
        .OFFS_W     (OFFS_W)
    ) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (byte_ok),
        .wr_offs   (cur_offs),
        .wr_data   (byte_data),
        .clear     (clear),
        .rd_offs   (scan_idx),
        .rd_data   (rd_data),
        .rd_valid  (rd_valid),
        .any_valid (any_valid)
    );

    pwb_commit_seq #(
        .PAGE_BYTES  (PAGE_BYTES),
        .OFFS_W      (OFFS_W),
        .CYCLE_TICKS (CYCLE_TICKS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .tick      (tick),
        .busy      (busy),
        .scan_en   (scan_en),
        .scan_idx  (scan_idx),
        .scan_last (scan_last)
    );

    assign mem_we    = scan_en && rd_valid;
    assign mem_addr  = {cur_page, scan_idx};
    assign mem_wdata = rd_data;

endmodule

// File: rtl/page_write_buffer_chk.sv
module page_write_buffer_chk #(
    parameter int OFFS_W = 5,
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_stb,
    input logic              wp,
    input logic              tick,
    input logic              busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr
);

    p_we_inside_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    p_busy_rise_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(stop_stb) && !$past(wp)));

    p_busy_fall_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tick));

    p_page_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[ADDR_W-1:OFFS_W] == $past(mem_addr[ADDR_W-1:OFFS_W])));

    p_ascending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |->
            (mem_addr[OFFS_W-1:0] > $past(mem_addr[OFFS_W-1:0])));

    p_wp_stop_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_stb && wp && !busy) |=> !busy);

endmodule

bind page_write_buffer page_write_buffer_chk #(
    .OFFS_W (OFFS_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .stop_stb (stop_stb),
    .wp       (wp),
    .tick     (tick),
    .busy     (busy),
    .mem_we   (mem_we),
    .mem_addr (mem_addr)
);

// File: tb/page_write_buffer_test.sv
`timescale 1ns/1ps
module page_write_buffer_test;

    localparam int PB    = 32;
    localparam int NP    = 64;
    localparam int DW    = 8;
    localparam int CT    = 3;
    localparam int OW    = 5;
    localparam int AW    = 11;
    localparam int DEPTH = PB * NP;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          addr_load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic          byte_stb = 1'b0;
    logic [DW-1:0] byte_data = '0;
    logic          stop_stb = 1'b0;
    logic          wp = 1'b0;
    logic          tick = 1'b0;
    logic          busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          obs_clr = 1'b0;

    page_write_buffer #(
        .PAGE_BYTES (PB), .PAGES (NP), .DATA_W (DW), .CYCLE_TICKS (CT)
    ) uut (
        .clk (clk), .rst_n (rst_n), .addr_load (addr_load), .addr_in (addr_in),
        .byte_stb (byte_stb), .byte_data (byte_data), .stop_stb (stop_stb),
        .wp (wp), .tick (tick), .busy (busy), .mem_we (mem_we),
        .mem_addr (mem_addr), .mem_wdata (mem_wdata)
    );

    // Array model driven only by the block's write port
    logic [DW-1:0] arr [DEPTH];
    int            wr_cnt;
    logic          order_bad, seen;
    logic [AW-1:0] last_addr;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
            wr_cnt <= 0; order_bad <= 1'b0; seen <= 1'b0; last_addr <= '0;
        end else if (obs_clr) begin
            wr_cnt <= 0; order_bad <= 1'b0; seen <= 1'b0;
        end else if (mem_we) begin
            arr[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
            if (seen && ((mem_addr[AW-1:OW] != last_addr[AW-1:OW]) ||
                         (mem_addr[OW-1:0] <= last_addr[OW-1:0])))
                order_bad <= 1'b1;
            last_addr <= mem_addr;
            seen <= 1'b1;
        end
    end

    // Expected state computed from the requirements
    logic [DW-1:0] exp_arr [DEPTH];
    logic [DW-1:0] pend_dat [PB];
    logic          pend_vld [PB];
    int            m_page, m_off;
    int            n_chk = 0, n_bad = 0;
    bit            finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic pend_clear();
        for (int i = 0; i < PB; i++) pend_vld[i] = 1'b0;
    endtask

    task automatic do_load(input int a);
        addr_load = 1'b1; addr_in = AW'(a);
        @(negedge clk);
        addr_load = 1'b0;
        m_page = a / PB; m_off = a % PB;      // R2
        pend_clear();
    endtask

    task automatic put(input int d);
        byte_stb = 1'b1; byte_data = DW'(d);
        @(negedge clk);
        byte_stb = 1'b0;
        if (!wp) begin                         // R3, R4, R8
            pend_dat[m_off] = DW'(d);
            pend_vld[m_off] = 1'b1;
            m_off = (m_off + 1) % PB;
        end
    endtask

    task automatic cmp_array(input string req);
        int mism = 0;
        for (int i = 0; i < DEPTH; i++) if (arr[i] !== exp_arr[i]) mism++;
        chk(mism == 0, req, mism, 0);
    endtask

    // Ends a transaction with STOP; disturb fires strobes during the scan (R7)
    task automatic finish(input bit tick_in_scan, input bit disturb, input string req);
        int nv = 0;
        bit commit;
        for (int i = 0; i < PB; i++) if (pend_vld[i]) nv++;
        commit = (nv > 0) && !wp;
        stop_stb = 1'b1; obs_clr = 1'b1;
        @(negedge clk);
        stop_stb = 1'b0; obs_clr = 1'b0;
        chk(busy == commit, commit ? "R6 busy rise" : "R9 no busy", busy, commit);
        if (commit)
            for (int i = 0; i < PB; i++)
                if (pend_vld[i]) exp_arr[m_page * PB + i] = pend_dat[i];
        pend_clear();
        for (int k = 0; k < PB + 3; k++) begin
            tick = tick_in_scan && (k < 20);
            if (disturb) begin
                addr_load = (k == 3); addr_in = AW'((m_page ^ 7) * PB + 9);
                byte_stb  = (k > 5 && k < 12); byte_data = DW'(8'hA5 + k);
                stop_stb  = (k == 14);
            end
            @(negedge clk);
            tick = 1'b0; addr_load = 1'b0; byte_stb = 1'b0; stop_stb = 1'b0;
        end
        if (commit) begin
            chk(busy == 1'b1, "R6 busy through scan", busy, 1);
            for (int k = 0; k < CT; k++) begin
                tick = 1'b1;
                @(negedge clk);
                tick = 1'b0;
                chk(busy == (k != CT - 1), "R6 busy vs tick count", busy, (k != CT - 1));
            end
            chk(order_bad == 1'b0, "R5 order/page", order_bad, 0);
        end else begin
            chk(busy == 1'b0, "R9 stays idle", busy, 0);
        end
        chk(wr_cnt == (commit ? nv : 0), "R5 write count", wr_cnt, commit ? nv : 0);
        cmp_array(req);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) exp_arr[i] = '0;
        pend_clear(); m_page = 0; m_off = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1 busy in reset", busy, 0);
        chk(mem_we == 1'b0, "R1 we in reset", mem_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_we == 1'b0, "R1 after reset", {busy, mem_we}, 0);

        // Sweep every start offset and several lengths (R3 wrap, R4 overwrite, R5)
        for (int s = 0; s < PB; s++) begin
            for (int li = 0; li < 4; li++) begin
                int n, pg;
                n  = (li == 0) ? 1 : (li == 1) ? 7 : (li == 2) ? 32 : 37;
                pg = (s * 5 + li * 17) % NP;
                do_load(pg * PB + s);
                for (int i = 0; i < n; i++) put((s * 7 + n * 13 + i * 29 + pg) & 8'hFF);
                finish(li == 2, 1'b0, (n > PB) ? "R4 overwrite array" : "R3 page wrap array");
            end
        end

        // R8: protected bytes skipped without advancing the offset
        do_load(5 * PB + 28);
        put(8'h11); put(8'h22);
        wp = 1'b1; put(8'h33); put(8'h44);
        wp = 1'b0; put(8'h55); put(8'h66);
        finish(1'b0, 1'b0, "R8 protected bytes dropped");

        // R9: empty transaction, then protected STOP
        do_load(9 * PB + 3);
        finish(1'b0, 1'b0, "R9 empty stop");
        do_load(10 * PB + 0);
        put(8'h77); put(8'h78);
        wp = 1'b1;
        finish(1'b0, 1'b0, "R9 protected stop");
        wp = 1'b0;
        do_load(10 * PB + 0);
        finish(1'b0, 1'b0, "R9 buffer emptied");

        // R2: a second load discards the first load's bytes
        do_load(12 * PB + 4);
        put(8'hC1); put(8'hC2); put(8'hC3);
        do_load(13 * PB + 30);
        put(8'hD1); put(8'hD2); put(8'hD3);
        finish(1'b0, 1'b0, "R2 reload discards");

        // R7: strobes during busy leave no trace
        do_load(20 * PB + 10);
        put(8'hE1); put(8'hE2);
        finish(1'b0, 1'b1, "R7 disturbed commit");
        finish(1'b0, 1'b0, "R7 bare stop after busy");
        put(8'hF1); put(8'hF2);
        finish(1'b0, 1'b0, "R7 offset kept across busy");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule